// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block handles interrupt entry and return for a small 16-bit processor that uses real-mode addressing. It holds the architectural code segment, instruction pointer, flags word and stack pointer. The block takes a maskable request, a non-maskable request or a return request only at an instruction boundary. On entry it pushes the flags word, then the code segment, then the instruction pointer onto a downward-growing word stack. It then clears the interrupt-enable and trace flags and reads the handler's far address from a table in low memory, where each slot is four bytes wide. On return it pops the three saved words and puts them back.

The memory side is a word bus with one request per cycle. A write completes at the clock edge. Read data appears on `mem_rdata` in the cycle after the read is issued. While the block is idle, a load port lets the surrounding core write the four architectural registers. The core decodes instructions, runs the ALU and picks among interrupt sources. None of that is part of this block.

Top module: `irq_seq`

## Requirements
- R1: An accepted entry writes three words: the flags at SP-2, CS at SP-4 and IP at SP-6, in that order, one write per cycle. SP ends at its old value minus 6.
- R2: The flags word is pushed with its old contents. After the push, bit 9 (interrupt enable) and bit 8 (trace) of the flags register are cleared, and the other bits keep their values.
- R3: After the pushes the block reads the word at byte address vector*4 into IP and the word at vector*4+2 into CS. These are two reads from the table that starts at address 0.
- R4: A maskable request is ignored while flags bit 9 is 0. Any request without `at_boundary` is ignored. An ignored request leaves every register unchanged and `busy` low.
- R5: A non-maskable request is taken whatever flags bit 9 holds. It uses the fixed vector NMI_VEC (default 2) and wins over a maskable request at the same boundary.
- R6: A return reads IP from SP, CS from SP+2 and the flags word from SP+4, including bit 9. SP ends at its old value plus 6.
- R7: `busy` is high for 6 cycles on an entry and 4 cycles on a return, starting in the cycle after acceptance. `done` pulses high for exactly one cycle as `busy` falls, and the new register values are valid at that point.
- R8: After reset CS=F000h, IP=FFF0h, flags=0002h and SP=0800h. Values on the load port are ignored while `busy` is high.
- R9: A return request at a boundary wins over any interrupt request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| at_boundary | input | 1 | The current instruction is finishing this cycle |
| irq_req | input | 1 | Maskable interrupt request |
| irq_vec | input | VEC_W | Vector number for the maskable request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| iret_req | input | 1 | Return-from-interrupt request |
| ld_en | input | 1 | Load all four architectural registers while idle |
| ld_cs | input | 16 | Value to load into CS |
| ld_ip | input | 16 | Value to load into IP |
| ld_flags | input | 16 | Value to load into the flags register |
| ld_sp | input | 16 | Value to load into SP |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | ADDR_W | Byte address (always even) |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the cycle after the read is issued |
| cs_out | output | 16 | Code segment |
| ip_out | output | 16 | Instruction pointer |
| flags_out | output | 16 | Flags word |
| sp_out | output | 16 | Stack pointer |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence ends |

## Verification
Entry is run from a maskable request with both flags set, and from a non-maskable request with interrupts disabled. This shows that the saved flags keep their old bits while the live flags are cleared, and that the table slot follows the vector number. Two returns in a row unwind nested frames and restore the enable bit. A separate stack frame preset at another SP separates the pop order from the push order. Requests that arrive with no boundary, with the enable bit low, or together with a higher-priority request confirm the acceptance rules. A load attempted during a sequence confirms that the load port is blocked while busy.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int WORD_W = 16;
  localparam int IF_BIT = 9;
  localparam int TF_BIT = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH_FL,
    ST_PUSH_CS,
    ST_PUSH_IP,
    ST_VEC_LO,
    ST_VEC_HI,
    ST_VEC_END,
    ST_POP_IP,
    ST_POP_CS,
    ST_POP_FL,
    ST_POP_END
  } seq_st_t;
endpackage

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int NMI_VEC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             at_boundary,
  input  logic             irq_req,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic             nmi_req,
  input  logic             iret_req,
  input  logic             if_flag,
  output seq_st_t          st,
  output logic [VEC_W-1:0] vec_q,
  output logic             start,
  output logic             done
);
  logic idle, take_ret, take_nmi, take_irq;

  always_comb begin
    idle     = (st == ST_IDLE);
    take_ret = idle && at_boundary && iret_req;
    take_nmi = idle && at_boundary && !iret_req && nmi_req;
    take_irq = idle && at_boundary && !iret_req && !nmi_req && irq_req && if_flag;
    start    = take_ret || take_nmi || take_irq;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      vec_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= (st == ST_VEC_END) || (st == ST_POP_END);
      unique case (st)
        ST_IDLE: begin
          if (take_ret) begin
            st <= ST_POP_IP;
          end else if (take_nmi) begin
            st    <= ST_PUSH_FL;
            vec_q <= VEC_W'(NMI_VEC);
          end else if (take_irq) begin
            st    <= ST_PUSH_FL;
            vec_q <= irq_vec;
          end
        end
        ST_PUSH_FL: st <= ST_PUSH_CS;
        ST_PUSH_CS: st <= ST_PUSH_IP;
        ST_PUSH_IP: st <= ST_VEC_LO;
        ST_VEC_LO:  st <= ST_VEC_HI;
        ST_VEC_HI:  st <= ST_VEC_END;
        ST_VEC_END: st <= ST_IDLE;
        ST_POP_IP:  st <= ST_POP_CS;
        ST_POP_CS:  st <= ST_POP_FL;
        ST_POP_FL:  st <= ST_POP_END;
        ST_POP_END: st <= ST_IDLE;
        default:    st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_seq_regs.sv
module irq_seq_regs
  import irq_seq_pkg::*;
#(
  parameter logic [15:0] CS_RST    = 16'hF000,
  parameter logic [15:0] IP_RST    = 16'hFFF0,
  parameter logic [15:0] FLAGS_RST = 16'h0002,
  parameter logic [15:0] SP_RST    = 16'h0800
) (
  input  logic        clk,
  input  logic        rst,
  input  seq_st_t     st,
  input  logic        start,
  input  logic [15:0] mem_rdata,
  input  logic        ld_en,
  input  logic [15:0] ld_cs,
  input  logic [15:0] ld_ip,
  input  logic [15:0] ld_flags,
  input  logic [15:0] ld_sp,
  output logic [15:0] cs_q,
  output logic [15:0] ip_q,
  output logic [15:0] flags_q,
  output logic [15:0] sp_q
);
  localparam logic [15:0] STEP = 16'd2;
  logic [15:0] off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q    <= CS_RST;
      ip_q    <= IP_RST;
      flags_q <= FLAGS_RST;
      sp_q    <= SP_RST;
      off_q   <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (ld_en && !start) begin
            cs_q    <= ld_cs;
            ip_q    <= ld_ip;
            flags_q <= ld_flags;
            sp_q    <= ld_sp;
          end
        end
        ST_PUSH_FL: begin
          sp_q            <= sp_q - STEP;
          flags_q[IF_BIT] <= 1'b0;
          flags_q[TF_BIT] <= 1'b0;
        end
        ST_PUSH_CS, ST_PUSH_IP: sp_q <= sp_q - STEP;
        ST_VEC_HI:  off_q <= mem_rdata;
        ST_VEC_END: begin
          ip_q <= off_q;
          cs_q <= mem_rdata;
        end
        ST_POP_IP: sp_q <= sp_q + STEP;
        ST_POP_CS: begin
          ip_q <= mem_rdata;
          sp_q <= sp_q + STEP;
        end
        ST_POP_FL: begin
          cs_q <= mem_rdata;
          sp_q <= sp_q + STEP;
        end
        ST_POP_END: flags_q <= mem_rdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_seq_bus.sv
module irq_seq_bus
  import irq_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int VEC_W  = 8
) (
  input  seq_st_t           st,
  input  logic [15:0]       sp_q,
  input  logic [15:0]       cs_q,
  input  logic [15:0]       ip_q,
  input  logic [15:0]       flags_q,
  input  logic [VEC_W-1:0]  vec_q,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata
);
  logic [ADDR_W-1:0] stk_top, stk_next, tbl_slot;

  always_comb begin
    stk_top         = '0;
    stk_top[15:0]   = sp_q;
    stk_next        = '0;
    stk_next[15:0]  = sp_q - 16'd2;
    tbl_slot        = '0;
    tbl_slot[VEC_W+1:0] = {vec_q, 2'b00};

    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st)
      ST_PUSH_FL: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = stk_next; mem_wdata = flags_q;
      end
      ST_PUSH_CS: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = stk_next; mem_wdata = cs_q;
      end
      ST_PUSH_IP: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = stk_next; mem_wdata = ip_q;
      end
      ST_VEC_LO: begin
        mem_req = 1'b1; mem_addr = tbl_slot;
      end
      ST_VEC_HI: begin
        mem_req = 1'b1; mem_addr = tbl_slot | ADDR_W'(2);
      end
      ST_POP_IP, ST_POP_CS, ST_POP_FL: begin
        mem_req = 1'b1; mem_addr = stk_top;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int          ADDR_W    = 20,
  parameter int          VEC_W     = 8,
  parameter int          NMI_VEC   = 2,
  parameter logic [15:0] CS_RST    = 16'hF000,
  parameter logic [15:0] IP_RST    = 16'hFFF0,
  parameter logic [15:0] FLAGS_RST = 16'h0002,
  parameter logic [15:0] SP_RST    = 16'h0800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              at_boundary,
  input  logic              irq_req,
  input  logic [VEC_W-1:0]  irq_vec,
  input  logic              nmi_req,
  input  logic              iret_req,
  input  logic              ld_en,
  input  logic [15:0]       ld_cs,
  input  logic [15:0]       ld_ip,
  input  logic [15:0]       ld_flags,
  input  logic [15:0]       ld_sp,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  output logic [15:0]       cs_out,
  output logic [15:0]       ip_out,
  output logic [15:0]       flags_out,
  output logic [15:0]       sp_out,
  output logic              busy,
  output logic              done
);
  seq_st_t          st;
  logic [VEC_W-1:0] vec_q;
  logic             start;

  irq_seq_fsm #(.VEC_W(VEC_W), .NMI_VEC(NMI_VEC)) u_fsm (
    .clk(clk), .rst(rst), .at_boundary(at_boundary), .irq_req(irq_req),
    .irq_vec(irq_vec), .nmi_req(nmi_req), .iret_req(iret_req),
    .if_flag(flags_out[IF_BIT]), .st(st), .vec_q(vec_q), .start(start),
    .done(done)
  );

  irq_seq_regs #(.CS_RST(CS_RST), .IP_RST(IP_RST), .FLAGS_RST(FLAGS_RST),
                 .SP_RST(SP_RST)) u_regs (
    .clk(clk), .rst(rst), .st(st), .start(start), .mem_rdata(mem_rdata),
    .ld_en(ld_en), .ld_cs(ld_cs), .ld_ip(ld_ip), .ld_flags(ld_flags),
    .ld_sp(ld_sp), .cs_q(cs_out), .ip_q(ip_out), .flags_q(flags_out),
    .sp_q(sp_out)
  );

  irq_seq_bus #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_bus (
    .st(st), .sp_q(sp_out), .cs_q(cs_out), .ip_q(ip_out),
    .flags_q(flags_out), .vec_q(vec_q), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  assign busy = (st != ST_IDLE);
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter int ADDR_W = 20,
  parameter int VEC_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              at_boundary,
  input logic              irq_req,
  input logic              nmi_req,
  input logic              iret_req,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [15:0]       flags_out,
  input logic [15:0]       sp_out,
  input logic              busy,
  input logic              done
);
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |=> sp_out == $past(sp_out) - 16'd2); // R1

  AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we && $past(mem_req && mem_we) |-> !flags_out[9] && !flags_out[8]); // R2

  AST_TABLE_LOW: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_we && $past(mem_req && mem_we) |-> mem_addr[ADDR_W-1:VEC_W+2] == '0 && mem_addr[1:0] == 2'b00); // R3

  AST_MASKED_IGNORED: assert property (@(posedge clk) disable iff (rst)
    !busy && at_boundary && irq_req && !nmi_req && !iret_req && !flags_out[9] |=> !busy); // R4

  AST_NO_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    !busy && !at_boundary |=> !busy); // R4

  AST_NMI_TAKEN: assert property (@(posedge clk) disable iff (rst)
    !busy && at_boundary && nmi_req && !iret_req |=> busy && mem_we); // R5

  AST_RET_FIRST: assert property (@(posedge clk) disable iff (rst)
    !busy && at_boundary && iret_req |=> busy && mem_req && !mem_we); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $fell(busy)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
endmodule

bind irq_seq irq_seq_chk #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_chk (.*);

// File: tb/irq_seq_bench.sv
module irq_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        at_boundary, irq_req, nmi_req, iret_req, ld_en;
  logic [7:0]  irq_vec;
  logic [15:0] ld_cs, ld_ip, ld_flags, ld_sp;
  logic        mem_req, mem_we, busy, done;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [15:0] cs_out, ip_out, flags_out, sp_out;

  logic [15:0] mem [0:2047];
  logic        tb_wr;
  logic [10:0] tb_idx;
  logic [15:0] tb_data;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_seq u_irq_seq (
    .clk(clk), .rst(rst), .at_boundary(at_boundary), .irq_req(irq_req),
    .irq_vec(irq_vec), .nmi_req(nmi_req), .iret_req(iret_req),
    .ld_en(ld_en), .ld_cs(ld_cs), .ld_ip(ld_ip), .ld_flags(ld_flags),
    .ld_sp(ld_sp), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cs_out(cs_out),
    .ip_out(ip_out), .flags_out(flags_out), .sp_out(sp_out), .busy(busy),
    .done(done)
  );

  always @(posedge clk) begin
    if (tb_wr) mem[tb_idx] <= tb_data;
    else if (mem_req && mem_we) mem[mem_addr[11:1]] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[11:1]];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [15:0] byte_addr, input logic [15:0] val);
    @(negedge clk);
    tb_wr = 1'b1; tb_idx = byte_addr[11:1]; tb_data = val;
    @(negedge clk);
    tb_wr = 1'b0;
  endtask

  task automatic load(input logic [15:0] c, input logic [15:0] i,
                      input logic [15:0] f, input logic [15:0] s);
    @(negedge clk);
    ld_en = 1'b1; ld_cs = c; ld_ip = i; ld_flags = f; ld_sp = s;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // Drives one boundary cycle with the given requests, returns busy-cycle count.
  task automatic pulse(input logic bnd, input logic irq, input logic nmi,
                       input logic ret, input logic [7:0] v, output int n);
    @(negedge clk);
    at_boundary = bnd; irq_req = irq; nmi_req = nmi; iret_req = ret; irq_vec = v;
    @(negedge clk);
    at_boundary = 1'b0; irq_req = 1'b0; nmi_req = 1'b0; iret_req = 1'b0;
    n = 0;
    for (int g = 0; g < 20 && !done; g++) begin
      if (busy) n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R8 reset cs", cs_out, 16'hF000);
    chk("R8 reset ip", ip_out, 16'hFFF0);
    chk("R8 reset flags", flags_out, 16'h0002);
    chk("R8 reset sp", sp_out, 16'h0800);
    chk("R7 reset busy", busy, 0);
  endtask

  task automatic t_irq_entry();
    int n;
    poke(16'h0084, 16'hABCD);
    poke(16'h0086, 16'h4000);
    load(16'h1234, 16'h5678, 16'h0302, 16'h0800);
    pulse(1, 1, 0, 0, 8'h21, n);
    chk("R7 entry busy cycles", n, 6);
    chk("R7 done pulse", done, 1);
    chk("R1 push flags", mem[11'h3FF], 16'h0302);
    chk("R1 push cs", mem[11'h3FE], 16'h1234);
    chk("R1 push ip", mem[11'h3FD], 16'h5678);
    chk("R1 sp after entry", sp_out, 16'h07FA);
    chk("R2 flags cleared", flags_out, 16'h0002);
    chk("R3 handler ip", ip_out, 16'hABCD);
    chk("R3 handler cs", cs_out, 16'h4000);
    @(negedge clk);
    chk("R7 done single", done, 0);
  endtask

  task automatic t_ignored();
    int n;
    pulse(1, 1, 0, 0, 8'h21, n);
    chk("R4 masked busy", n, 0);
    chk("R4 masked ip", ip_out, 16'hABCD);
    chk("R4 masked sp", sp_out, 16'h07FA);
  endtask

  task automatic t_nmi_with_load();
    int n;
    poke(16'h0008, 16'h1111);
    poke(16'h000A, 16'h2222);
    @(negedge clk);
    at_boundary = 1; nmi_req = 1; irq_vec = 8'h21;
    @(negedge clk);
    at_boundary = 0; nmi_req = 0;
    ld_en = 1; ld_cs = 16'hDEAD; ld_ip = 16'hBEEF; ld_flags = 16'h0FFF; ld_sp = 16'h0100;
    @(negedge clk);
    ld_en = 0;
    n = 0;
    for (int g = 0; g < 20 && !done; g++) @(negedge clk);
    chk("R5 nmi ip", ip_out, 16'h1111);
    chk("R5 nmi cs", cs_out, 16'h2222);
    chk("R5 nmi saved flags", mem[11'h3FC], 16'h0002);
    chk("R1 nmi sp", sp_out, 16'h07F4);
    chk("R8 load ignored busy", flags_out, 16'h0002);
  endtask

  task automatic t_returns();
    int n;
    pulse(1, 0, 0, 1, 8'h00, n);
    chk("R7 return busy cycles", n, 4);
    chk("R6 pop ip", ip_out, 16'hABCD);
    chk("R6 pop cs", cs_out, 16'h4000);
    chk("R6 sp", sp_out, 16'h07FA);
    pulse(1, 0, 0, 1, 8'h00, n);
    chk("R6 pop ip outer", ip_out, 16'h5678);
    chk("R6 pop cs outer", cs_out, 16'h1234);
    chk("R6 flags restore IF", flags_out, 16'h0302);
    chk("R6 sp outer", sp_out, 16'h0800);
  endtask

  task automatic t_no_boundary();
    int n;
    pulse(0, 1, 1, 0, 8'h21, n);
    chk("R4 no boundary busy", n, 0);
    chk("R4 no boundary ip", ip_out, 16'h5678);
  endtask

  task automatic t_nmi_beats_irq();
    int n;
    pulse(1, 1, 1, 0, 8'h21, n);
    chk("R5 nmi priority ip", ip_out, 16'h1111);
    chk("R5 nmi priority cs", cs_out, 16'h2222);
  endtask

  task automatic t_ret_priority();
    int n;
    poke(16'h0700, 16'h0AAA);
    poke(16'h0702, 16'h0BBB);
    poke(16'h0704, 16'h0200);
    load(16'h3333, 16'h4444, 16'h0200, 16'h0700);
    pulse(1, 1, 1, 1, 8'h21, n);
    chk("R9 ret wins busy", n, 4);
    chk("R9 ret wins ip", ip_out, 16'h0AAA);
    chk("R9 ret wins cs", cs_out, 16'h0BBB);
    chk("R9 ret wins flags", flags_out, 16'h0200);
    chk("R9 ret wins sp", sp_out, 16'h0706);
  endtask

  initial begin
    rst = 1; at_boundary = 0; irq_req = 0; nmi_req = 0; iret_req = 0;
    irq_vec = 0; ld_en = 0; ld_cs = 0; ld_ip = 0; ld_flags = 0; ld_sp = 0;
    tb_wr = 0; tb_idx = 0; tb_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_irq_entry();
    t_ignored();
    t_nmi_with_load();
    t_returns();
    t_no_boundary();
    load(16'h1234, 16'h5678, 16'h0200, 16'h0800);
    t_nmi_beats_irq();
    t_ret_priority();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule